// File: doc/BRIEF.md
# Per-Core Inter-Processor Interrupt Register File

This block keeps the interrupt-between-cores state of a single core behind a small, byte-addressed register window. The window holds a 32-bit pending word, a 32-bit enable word, a write-only set port and a write-only clear port at fixed offsets. It also holds a 32-byte message area that software can read and write with 1-, 2-, 4- or 8-byte accesses.

A send decoder outside the block drives a separate vector port to mark one pending bit per cycle. A single interrupt-request output stays high for as long as any pending bit is set. Software on the receiving core reads the pending word, clears the bits it has handled and exchanges arguments through the message area.

Bus responses are combinational within the cycle that presents the access. Write effects appear after the next rising clock edge. Illegal accesses are reported with an error flag. Misaligned ones are flagged and still carried out.

Top module: `ipi_core_regs`

## Requirements
- R1: After reset the pending word, the enable word and all 32 message bytes are zero, and `irq` is low.
- R2: Offset 0x04 stores the low 32 bits of any write and reads back zero-extended. Its value never influences `irq`.
- R3: A write to offset 0x00 raises `bus_err` and leaves the pending word unchanged. A read of 0x00 returns the pending word zero-extended, with no error.
- R4: A cycle with `set_valid` high sets pending bit `set_vec` (0..31). A write to offset 0x08 ORs the low 32 data bits into the pending word.
- R5: A write to offset 0x0C clears every pending bit that is 1 in the low 32 data bits. If a bit is set and cleared in the same cycle, the set wins.
- R6: Reads of offsets 0x08 and 0x0C return zero with no error.
- R7: `irq` is high exactly when the pending word is nonzero. It changes on the same clock edge as the pending word.
- R8: Offsets 0x20..0x3F form a little-endian byte array. `bus_size` encodes the length: 0=1, 1=2, 2=4, 3=8 bytes. A write stores data byte k at offset+k. A read returns the byte at offset+k in data byte k, and bytes at and above the length read as zero.
- R9: A message-area access whose offset plus length exceeds 0x40 raises `bus_err`, writes nothing and reads zero.
- R10: Any offset other than 0x00, 0x04, 0x08, 0x0C and 0x20..0x3F raises `bus_err`, reads zero and changes no state.
- R11: `bus_misalign` is high when the offset is not a multiple of the length. The access still completes unless another rule rejects it.
- R12: `bus_err`, `bus_misalign` and `bus_rdata` are zero when `bus_valid` is low. `bus_rdata` is also zero during writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset in the window |
| bus_size | input | 2 | Access length code (0=1, 1=2, 2=4, 3=8 bytes) |
| bus_wdata | input | 64 | Write data, little-endian |
| bus_rdata | output | 64 | Read data, combinational |
| bus_err | output | 1 | Access rejected |
| bus_misalign | output | 1 | Offset not a multiple of length |
| set_valid | input | 1 | Set-request strobe from a send decoder |
| set_vec | input | 5 | Pending bit to set |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted pending bit shows on `irq` at the edge after the set or clear that caused it, or at the next read of 0x00 if other bits are still pending. A misplaced or dropped message byte shows only at the next read that covers it. Random sized reads that overlap earlier writes at shifted offsets are therefore mixed in, so such faults surface within a few accesses. Decode faults show in the same cycle as the access, through the error flag and zeroed read data.

// File: rtl/ipi_regs_pkg.sv
package ipi_regs_pkg;
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 64;
  localparam int STAT_W     = 32;
  localparam int VEC_W      = $clog2(STAT_W);
  localparam int MBOX_BYTES = 32;
  localparam int MBOX_IDX_W = $clog2(MBOX_BYTES);
  localparam int LANES      = DATA_W / 8;

  localparam logic [ADDR_W-1:0] OFS_PEND  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_ENAB  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_SETP  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_CLRP  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_MBOX  = 8'h20;
  localparam logic [ADDR_W:0]   MBOX_END  = 9'h040;

  typedef struct packed {
    logic pend;
    logic enab;
    logic setp;
    logic clrp;
    logic mbox;
  } reg_sel_t;
endpackage

// File: rtl/ipi_access_decode.sv
module ipi_access_decode
  import ipi_regs_pkg::*;
(
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  output reg_sel_t          sel,
  output logic [3:0]        acc_len,
  output logic              err,
  output logic              misalign
);
  logic [ADDR_W:0] end_ofs;
  logic hit_pend, hit_enab, hit_setp, hit_clrp, hit_mbox;
  logic range_ok, known, reject;

  always_comb begin
    acc_len  = 4'd1 << bus_size;
    end_ofs  = {1'b0, bus_addr} + {5'd0, acc_len};
    hit_pend = (bus_addr == OFS_PEND);
    hit_enab = (bus_addr == OFS_ENAB);
    hit_setp = (bus_addr == OFS_SETP);
    hit_clrp = (bus_addr == OFS_CLRP);
    hit_mbox = (bus_addr >= OFS_MBOX) && ({1'b0, bus_addr} < MBOX_END);
    range_ok = (end_ofs <= MBOX_END);
    known    = hit_pend | hit_enab | hit_setp | hit_clrp | hit_mbox;
    reject   = !known | (hit_pend & bus_write) | (hit_mbox & !range_ok);
    err      = bus_valid & reject;
    misalign = bus_valid & (|(bus_addr[2:0] & (acc_len[2:0] - 3'd1)));
    sel.pend = bus_valid & !reject & hit_pend;
    sel.enab = bus_valid & !reject & hit_enab;
    sel.setp = bus_valid & !reject & hit_setp;
    sel.clrp = bus_valid & !reject & hit_clrp;
    sel.mbox = bus_valid & !reject & hit_mbox;
  end
endmodule

// File: rtl/ipi_status_core.sv
module ipi_status_core
  import ipi_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_valid,
  input  logic [VEC_W-1:0]  set_vec,
  input  logic              bus_set_en,
  input  logic              bus_clr_en,
  input  logic              bus_enab_we,
  input  logic [STAT_W-1:0] wdata,
  output logic [STAT_W-1:0] pend_q,
  output logic [STAT_W-1:0] enab_q,
  output logic              irq
);
  logic [STAT_W-1:0] set_mask, clr_mask, pend_d;
  logic              pend_ce, irq_d, irq_q;

  always_comb begin
    set_mask = '0;
    if (set_valid)  set_mask = set_mask | (STAT_W'(1) << set_vec);
    if (bus_set_en) set_mask = set_mask | wdata;
    clr_mask = bus_clr_en ? wdata : '0;
    pend_ce  = set_valid | bus_set_en | bus_clr_en;
    pend_d   = (pend_q & ~clr_mask) | set_mask;
    irq_d    = |pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else if (pend_ce) begin
      pend_q <= pend_d;
      irq_q  <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           enab_q <= '0;
    else if (bus_enab_we) enab_q <= wdata;
  end

  assign irq = irq_q;

  // R7: request line follows the pending word
  a_r7_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (pend_q != '0));
  // R4: port set lands in the pending word
  a_r4_port_set: assert property (@(posedge clk) disable iff (!rst_n)
    set_valid |=> pend_q[$past(set_vec)]);
  // R5: cleared bits are gone when nothing sets them
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_clr_en && !set_valid && !bus_set_en) |=> ((pend_q & $past(wdata)) == '0));
  // R3: pending word only moves on set or clear
  a_r3_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_valid || bus_set_en || bus_clr_en) |=> $stable(pend_q));
  // R2: enable word only moves on its own write
  a_r2_enab_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_enab_we |=> $stable(enab_q));
endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox
  import ipi_regs_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_en,
  input  logic                  wr,
  input  logic [MBOX_IDX_W-1:0] idx,
  input  logic [3:0]            len,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata
);
  logic [MBOX_BYTES*8-1:0] mem_q;
  logic                    wr_en;

  assign wr_en = acc_en & wr;

  for (genvar j = 0; j < MBOX_BYTES; j++) begin : g_byte
    logic [MBOX_IDX_W:0] rel;
    logic                hit;
    logic [7:0]          byte_d;
    always_comb begin
      rel    = (MBOX_IDX_W+1)'(j) - {1'b0, idx};
      hit    = wr_en && ((MBOX_IDX_W+1)'(j) >= {1'b0, idx}) && (rel < {2'b0, len});
      byte_d = wdata[rel[2:0]*8 +: 8];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem_q[j*8 +: 8] <= '0;
      else if (hit) mem_q[j*8 +: 8] <= byte_d;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [MBOX_IDX_W:0] pos;
    always_comb begin
      pos = {1'b0, idx} + (MBOX_IDX_W+1)'(k);
      if (acc_en && !wr && (k < int'(len)) && !pos[MBOX_IDX_W])
        rdata[k*8 +: 8] = mem_q[pos[MBOX_IDX_W-1:0]*8 +: 8];
      else
        rdata[k*8 +: 8] = 8'h00;
    end
  end

  // R9: storage untouched unless an accepted write targets it
  a_r9_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem_q));
  // R8: bytes above the access length read as zero
  a_r8_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !wr && len == 4'd1) |-> (rdata[DATA_W-1:8] == '0));
endmodule

// File: rtl/ipi_core_regs.sv
module ipi_core_regs
  import ipi_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  output logic              bus_misalign,
  input  logic              set_valid,
  input  logic [VEC_W-1:0]  set_vec,
  output logic              irq
);
  reg_sel_t          sel;
  logic [3:0]        acc_len;
  logic [STAT_W-1:0] pend_q, enab_q;
  logic [DATA_W-1:0] mb_rdata;

  ipi_access_decode u_dec (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .sel       (sel),
    .acc_len   (acc_len),
    .err       (bus_err),
    .misalign  (bus_misalign)
  );

  ipi_status_core u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_valid   (set_valid),
    .set_vec     (set_vec),
    .bus_set_en  (sel.setp & bus_write),
    .bus_clr_en  (sel.clrp & bus_write),
    .bus_enab_we (sel.enab & bus_write),
    .wdata       (bus_wdata[STAT_W-1:0]),
    .pend_q      (pend_q),
    .enab_q      (enab_q),
    .irq         (irq)
  );

  ipi_mailbox u_mbox (
    .clk    (clk),
    .rst_n  (rst_n),
    .acc_en (sel.mbox),
    .wr     (bus_write),
    .idx    (bus_addr[MBOX_IDX_W-1:0]),
    .len    (acc_len),
    .wdata  (bus_wdata),
    .rdata  (mb_rdata)
  );

  always_comb begin
    bus_rdata = '0;
    if (!bus_write) begin
      if (sel.pend)      bus_rdata = {{(DATA_W-STAT_W){1'b0}}, pend_q};
      else if (sel.enab) bus_rdata = {{(DATA_W-STAT_W){1'b0}}, enab_q};
      else if (sel.mbox) bus_rdata = mb_rdata;
    end
  end

  // R10: rejected reads carry no data
  a_r10_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && !bus_write) |-> (bus_rdata == '0));
  // R12: idle bus shows nothing
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> (!bus_err && !bus_misalign && bus_rdata == '0));
  // R6: set and clear ports read as zero without error
  a_r6_wo_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && (bus_addr == OFS_SETP || bus_addr == OFS_CLRP))
      |-> (bus_rdata == '0 && !bus_err));
endmodule

// File: tb/ipi_core_regs_tb.sv
`timescale 1ns/1ps
module ipi_core_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_write;
  logic [7:0]  bus_addr;
  logic [1:0]  bus_size;
  logic [63:0] bus_wdata, bus_rdata;
  logic        bus_err, bus_misalign;
  logic        set_valid;
  logic [4:0]  set_vec;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_pend, m_enab;
  logic [7:0]  m_mb [32];

  always #4 clk = ~clk;

  ipi_core_regs dut_i (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int f_len(logic [1:0] sz);
    return 1 << sz;
  endfunction

  function automatic bit f_mb(logic [7:0] a);
    return a >= 8'h20 && a < 8'h40;
  endfunction

  function automatic bit f_err(bit w, logic [7:0] a, logic [1:0] sz);
    if (a == 8'h00) return w;
    if (a == 8'h04 || a == 8'h08 || a == 8'h0C) return 0;
    if (f_mb(a)) return (int'(a) + f_len(sz)) > 64;
    return 1;
  endfunction

  function automatic logic [63:0] f_rd(bit w, logic [7:0] a, logic [1:0] sz);
    logic [63:0] r = '0;
    if (w || f_err(w, a, sz)) return '0;
    if (a == 8'h00) return {32'd0, m_pend};
    if (a == 8'h04) return {32'd0, m_enab};
    if (f_mb(a))
      for (int k = 0; k < f_len(sz); k++) r[k*8 +: 8] = m_mb[int'(a) - 32 + k];
    return r;
  endfunction

  function automatic string f_tag(bit w, logic [7:0] a, logic [1:0] sz);
    if (a == 8'h00) return w ? "R3 status write" : "R3 status read";
    if (a == 8'h04) return "R2 enable";
    if (a == 8'h08 || a == 8'h0C) return w ? "R4/R5 set-clear" : "R6 wo read";
    if (f_mb(a)) return f_err(w, a, sz) ? "R9 range" : "R8 mailbox";
    return "R10 unknown";
  endfunction

  task automatic op(bit v, bit w, logic [7:0] a, logic [1:0] sz, logic [63:0] d,
                    bit sv, logic [4:0] vec);
    logic [31:0] setm, clrm;
    string t;
    @(negedge clk);
    bus_valid = v; bus_write = w; bus_addr = a; bus_size = sz; bus_wdata = d;
    set_valid = sv; set_vec = vec;
    #1;
    t = f_tag(w, a, sz);
    if (v) begin
      check({t, " err"}, {63'd0, bus_err}, {63'd0, f_err(w, a, sz)});
      check("R11 misalign", {63'd0, bus_misalign}, {63'd0, (int'(a) % f_len(sz)) != 0});
      check({t, " rdata"}, bus_rdata, f_rd(w, a, sz));
    end else begin
      check("R12 idle", {bus_rdata, bus_err, bus_misalign}, '0);
    end
    setm = sv ? (32'd1 << vec) : 32'd0;
    clrm = '0;
    if (v && w && !f_err(w, a, sz)) begin
      if (a == 8'h04) m_enab = d[31:0];
      if (a == 8'h08) setm = setm | d[31:0];
      if (a == 8'h0C) clrm = d[31:0];
      if (f_mb(a))
        for (int k = 0; k < f_len(sz); k++) m_mb[int'(a) - 32 + k] = d[k*8 +: 8];
    end
    m_pend = (m_pend & ~clrm) | setm;
    @(posedge clk);
    #1;
    check("R7 irq", {63'd0, irq}, {63'd0, m_pend != 0});
  endtask

  task automatic rd(logic [7:0] a, logic [1:0] sz);
    op(1, 0, a, sz, '0, 0, '0);
  endtask
  task automatic wr(logic [7:0] a, logic [1:0] sz, logic [63:0] d);
    op(1, 1, a, sz, d, 0, '0);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240705));
    rst_n = 0; bus_valid = 0; bus_write = 0; bus_addr = '0; bus_size = '0;
    bus_wdata = '0; set_valid = 0; set_vec = '0;
    m_pend = '0; m_enab = '0;
    for (int i = 0; i < 32; i++) m_mb[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    // R1 reset state
    check("R1 irq", {63'd0, irq}, '0);
    rd(8'h00, 2'd2); rd(8'h04, 2'd2);
    for (int i = 0; i < 4; i++) rd(8'h20 + 8'(i * 8), 2'd3);
    // R2 enable does not raise irq
    wr(8'h04, 2'd3, 64'hDEAD_BEEF_FFFF_FFFF); rd(8'h04, 2'd2);
    // R4 port sets and bus sets
    op(1, 0, 8'h00, 2'd2, '0, 1, 5'd5);
    op(0, 0, 8'h00, 2'd0, '0, 1, 5'd31);
    rd(8'h00, 2'd2);
    wr(8'h08, 2'd2, 64'h0000_0000_0000_0300); rd(8'h00, 2'd2);
    // R3 status write rejected
    wr(8'h00, 2'd2, 64'h0); rd(8'h00, 2'd2);
    // R5 clear, and set beating clear on the same bit
    wr(8'h0C, 2'd2, 64'h0000_0000_8000_0320); rd(8'h00, 2'd2);
    op(1, 1, 8'h0C, 2'd2, 64'h0000_0000_0000_0400, 1, 5'd10); rd(8'h00, 2'd2);
    wr(8'h0C, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF); rd(8'h00, 2'd2);
    // R6 write-only ports read zero
    rd(8'h08, 2'd2); rd(8'h0C, 2'd3);
    // R8 sized little-endian access
    wr(8'h28, 2'd3, 64'h1122_3344_5566_7788);
    rd(8'h2A, 2'd0); rd(8'h2C, 2'd1); rd(8'h28, 2'd2); rd(8'h28, 2'd3);
    wr(8'h3F, 2'd0, 64'hFFFF_FFFF_FFFF_FFA5); rd(8'h38, 2'd3);
    // R9 range overrun
    wr(8'h3C, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF); rd(8'h38, 2'd3); rd(8'h3E, 2'd2);
    // R10 unknown offsets
    rd(8'h10, 2'd2); wr(8'h50, 2'd3, 64'h1); rd(8'h01, 2'd0); wr(8'h1C, 2'd2, 64'h5);
    // R11 misaligned but completed
    wr(8'h21, 2'd1, 64'h0000_0000_0000_BEEF); rd(8'h21, 2'd1); rd(8'h20, 2'd3);
    wr(8'h04, 2'd3, 64'h0000_0000_1234_5678);
    // random mix
    for (int n = 0; n < 1500; n++) begin
      logic [7:0]  a;
      logic [1:0]  sz;
      logic [63:0] d;
      int sel = $urandom_range(0, 9);
      sz = 2'($urandom_range(0, 3));
      case (sel)
        0: a = 8'h00;
        1: a = 8'h04;
        2: a = 8'h08;
        3: a = 8'h0C;
        4: a = 8'($urandom_range(0, 255));
        default: a = 8'h20 + 8'($urandom_range(0, 31));
      endcase
      d = {$urandom, $urandom};
      if (a == 8'h0C && ($urandom_range(0, 1) == 1)) d[31:0] = d[31:0] & $urandom;
      op($urandom_range(0, 7) != 0, $urandom_range(0, 1) == 1, a, sz, d,
         $urandom_range(0, 3) == 0, 5'($urandom_range(0, 31)));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule